// File: doc/BRIEF.md
# Hyper Page DRAM Controller

This controller connects a single-beat synchronous request port to an asynchronous 16-bit, 1M-word DRAM with hyper page (EDO-style) column cycles. A requester presents a 20-bit word address, write data, two byte enables and a read/write flag under a valid/ready handshake. Reads come back one cycle after the column access as a single-cycle valid pulse with the data. The upper ten address bits select the row, which goes onto the shared address pins while RAS is asserted. The lower ten select the column, which goes onto the same pins for the column strobe.

After an access the row stays open, so a later request to the same row becomes a short column cycle without a new activation. Reads and writes can be mixed inside one open row. A request to another row precharges first and then activates the new row. A counter of RAS-low cycles closes the row on its own before the device's continuous RAS-low limit is reached. Writes use early-write timing, with WE and the data bus driven one cycle before the CAS strobes fall. Each byte lane has its own CAS strobe.

Refresh is carried out by a separate sequencer. The controller arbitrates with it through a request, grant and done handshake. All delays are given in clock cycles as parameters.

Top module: `hpdram_ctrl`

## Requirements
- R1: While reset is held, and after it, before any request: `dram_ras_n`, both `dram_cas_n` bits, `dram_we_n` and `dram_oe_n` are 1. `dram_dq_oe`, `rsp_valid` and `ref_grant` are 0.
- R2: The row, `req_addr[19:10]`, is on `dram_addr` in the cycle RAS falls. The column, `req_addr[9:0]`, is on `dram_addr` in the cycle the CAS strobes fall.
- R3: In a write, `dram_cas_n[0]` strobes only when `req_be[0]`=1 and carries DQ[7:0]. `dram_cas_n[1]` strobes only when `req_be[1]`=1 and carries DQ[15:8]. A byte whose enable is 0 keeps its old content.
- R4: Early write. `dram_we_n` is 0 and `dram_dq_oe` is 1 for at least one cycle before the CAS strobes of a write fall, and both stay that way until CAS rises. The data bus is driven only while `dram_we_n` is 0 and `dram_oe_n` is 1.
- R5: A read strobes both CAS bits with `dram_we_n`=1 and `dram_oe_n`=0. After the last CAS-low cycle, `rsp_valid` is 1 for exactly one cycle, with `rsp_rdata` equal to the stored word.
- R6: A request to the row that is currently open causes no new RAS falling edge.
- R7: A request to another row raises RAS for at least `T_RP` cycles before the next activation. CAS falls exactly `T_RCD`+1 cycles after RAS falls: `T_RCD` activation cycles followed by one column setup cycle.
- R8: RAS is never low for more than `T_RAS_MAX` consecutive cycles. An open row with no traffic is closed without any request.
- R9: While `ref_req` is 1, `req_ready` is 0. An open row is precharged first. `ref_grant` then stays 1, with RAS and both CAS high, until `ref_done`. The next access after a refresh performs a new activation.
- R10: Each CAS pulse lasts exactly `T_CAS` cycles. CAS falls only while RAS is low. Between two CAS pulses CAS is high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in [19:10], column in [9:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = DQ[7:0] |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | Refresh sequencer asks for the device |
| ref_grant | output | 1 | Device handed to the refresh sequencer |
| ref_done | input | 1 | Refresh sequencer finished |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes, bit 0 lower byte, bit 1 upper byte |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the device |

## Verification
The bench exercises the block against a cycle-level device model with these patterns:
- **Row and column values that differ.** Because of this, a swapped or shifted address multiplex lands the data at a visible wrong location.
- **Full-word and single-byte writes.** These show whether lane masking follows the enables or spills into the other byte.
- **Repeated same-row accesses against a row change.** Counting activations tells page hits from misses, and the model measures precharge and RAS-to-CAS distances.
- **A long idle spell and a long burst of same-row reads.** These stress the RAS-low limit.
- **A refresh request that arrives while a row is open.** This shows whether the row is closed, the grant is held and the row is reactivated afterwards.

// File: rtl/hpdram_ctrl.sv
module hpdram_ctrl #(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 1,
  parameter int T_RP      = 2,
  parameter int T_RAS_MAX = 4900
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       req_valid,
  output logic                                       req_ready,
  input  logic                                       req_write,
  input  logic [ROW_W+COL_W-1:0]                     req_addr,
  input  logic [DATA_W-1:0]                          req_wdata,
  input  logic [DATA_W/8-1:0]                        req_be,
  output logic                                       rsp_valid,
  output logic [DATA_W-1:0]                          rsp_rdata,
  input  logic                                       ref_req,
  output logic                                       ref_grant,
  input  logic                                       ref_done,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                                       dram_ras_n,
  output logic [DATA_W/8-1:0]                        dram_cas_n,
  output logic                                       dram_we_n,
  output logic                                       dram_oe_n,
  output logic [DATA_W-1:0]                          dram_dq_out,
  output logic                                       dram_dq_oe,
  input  logic [DATA_W-1:0]                          dram_dq_in
);
  localparam int AW    = ROW_W > COL_W ? ROW_W : COL_W;
  localparam int LANES = DATA_W / 8;
  localparam int TM0   = T_RCD > T_CAS ? T_RCD : T_CAS;
  localparam int TM    = TM0 > T_RP ? TM0 : T_RP;
  localparam int TW    = $clog2(TM + 1);
  localparam int CW    = $clog2(T_RAS_MAX + 1);
  localparam logic [TW-1:0] RCD_END = TW'(T_RCD - 1);
  localparam logic [TW-1:0] CAS_END = TW'(T_CAS);
  localparam logic [TW-1:0] RP_END  = TW'(T_RP - 1);
  localparam logic [CW-1:0] RAS_LIM = CW'(T_RAS_MAX - T_CAS - 3);

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_RD, S_WR, S_PRE, S_REF} state_t;

  state_t             state;
  logic [TW-1:0]      cnt;
  logic [CW-1:0]      ras_cnt;
  logic               row_open, pend_req, pend_ref;
  logic [ROW_W-1:0]   open_row, cmd_row;
  logic [COL_W-1:0]   cmd_col;
  logic               cmd_write;
  logic [LANES-1:0]   cmd_be;
  logic [DATA_W-1:0]  cmd_data;

  logic expire, hit, cas_on;
  assign expire    = row_open && (ras_cnt >= RAS_LIM);
  assign hit       = open_row == req_addr[ROW_W+COL_W-1:COL_W];
  assign req_ready = (state == S_IDLE) && !ref_req && !expire;
  assign ref_grant = state == S_REF;

  assign cas_on      = (state == S_RD || state == S_WR) && cnt != '0;
  assign dram_ras_n  = !(state == S_ACT || state == S_RD || state == S_WR ||
                         (state == S_IDLE && row_open));
  assign dram_cas_n  = ~({LANES{cas_on}} & ((state == S_WR) ? cmd_be : {LANES{1'b1}}));
  assign dram_we_n   = state != S_WR;
  assign dram_oe_n   = state != S_RD;
  assign dram_dq_oe  = state == S_WR;
  assign dram_dq_out = cmd_data;
  assign dram_addr   = (state == S_ACT) ? AW'(cmd_row) : AW'(cmd_col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      ras_cnt   <= '0;
      row_open  <= 1'b0;
      pend_req  <= 1'b0;
      pend_ref  <= 1'b0;
      open_row  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      cmd_write <= 1'b0;
      cmd_be    <= '0;
      cmd_data  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      ras_cnt   <= dram_ras_n ? '0 : ras_cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (ref_req) begin
            if (row_open) begin
              state    <= S_PRE;
              pend_ref <= 1'b1;
              row_open <= 1'b0;
            end else begin
              state <= S_REF;
            end
          end else if (expire) begin
            state    <= S_PRE;
            row_open <= 1'b0;
          end else if (req_valid) begin
            cmd_row   <= req_addr[ROW_W+COL_W-1:COL_W];
            cmd_col   <= req_addr[COL_W-1:0];
            cmd_write <= req_write;
            cmd_be    <= req_be;
            cmd_data  <= req_wdata;
            if (row_open && hit) begin
              state <= req_write ? S_WR : S_RD;
            end else if (row_open) begin
              state    <= S_PRE;
              pend_req <= 1'b1;
              row_open <= 1'b0;
            end else begin
              state <= S_ACT;
            end
          end
        end
        S_ACT: begin
          cnt <= cnt + 1'b1;
          if (cnt == RCD_END) begin
            cnt      <= '0;
            row_open <= 1'b1;
            open_row <= cmd_row;
            state    <= cmd_write ? S_WR : S_RD;
          end
        end
        S_RD, S_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CAS_END) begin
            cnt   <= '0;
            state <= S_IDLE;
            if (state == S_RD) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
          end
        end
        S_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt == RP_END) begin
            cnt <= '0;
            if (pend_ref) begin
              state    <= S_REF;
              pend_ref <= 1'b0;
            end else if (pend_req) begin
              state    <= S_ACT;
              pend_req <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_REF: if (ref_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpdram_ctrl_chk.sv
module hpdram_ctrl_chk #(
  parameter int LANES     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS_MAX = 4900
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             ref_grant,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dq_oe
);
  localparam int CW = $clog2(T_RAS_MAX + 2);
  localparam int HW = $clog2(T_RP + 1);

  logic [CW-1:0] low_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      hi_cnt  <= HW'(T_RP);
    end else begin
      low_cnt <= ras_n ? '0 : low_cnt + 1'b1;
      if (!ras_n)                  hi_cnt <= '0;
      else if (hi_cnt != HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R8
  ras_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CW'(T_RAS_MAX));

  // R7
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= HW'(T_RP));

  // R10
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(cas_n) & ~cas_n)) |-> !ras_n);

  // R4
  early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|($past(cas_n) & ~cas_n)) && !we_n) |-> $past(we_n) == 1'b0);

  // R4
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && oe_n));

  // R9
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> (ras_n && (&cas_n) && !req_ready));

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind hpdram_ctrl hpdram_ctrl_chk #(
  .LANES(LANES), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ref_grant(ref_grant), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe)
);

// File: tb/tb_hpdram_ctrl.sv
`timescale 1ns/1ps
module tb_hpdram_ctrl;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RAS_MAX = 60;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0, ref_done = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, ref_grant;
  logic [15:0] rsp_rdata, dq_out;
  logic [15:0] dq_in = '0;
  logic [9:0]  addr;
  logic        ras_n, we_n, oe_n, dq_oe;
  logic [1:0]  cas_n;

  always #10 clk = ~clk;

  hpdram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req),
    .ref_grant(ref_grant), .ref_done(ref_done), .dram_addr(addr), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // cycle-level device model, sampled 5 ns after each rising edge
  logic [15:0] mem [int unsigned];
  logic [9:0]  em_row = '0, em_col = '0;
  logic        p_ras = 1'b1, p_we = 1'b1;
  logic [1:0]  p_cas = 2'b11;
  int act_cnt = 0, hi_run = 100, low_run = 0, max_low = 0, bad_pre = 0;
  int since_ras = 0, first_rcd = -1, bad_cas = 0, late_we = 0, bad_rd = 0;
  int cas_low = 0, cas_hi = 100, bad_width = 0, min_cas_hi = 100;
  bit first_in_row = 1'b0, seen_pulse = 1'b0;

  function automatic logic [15:0] peek(input logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      since_ras++;
      if (p_ras && !ras_n) begin
        act_cnt++;
        em_row = addr;
        if (hi_run < T_RP) bad_pre++;
        since_ras = 0;
        first_in_row = 1'b1;
      end
      if (!ras_n) begin low_run++; hi_run = 0; end else begin low_run = 0; hi_run++; end
      if (low_run > max_low) max_low = low_run;
      if (|(p_cas & ~cas_n)) begin
        if (ras_n) bad_cas++;
        em_col = addr;
        if (first_in_row) begin first_rcd = since_ras; first_in_row = 1'b0; end
        if (seen_pulse && cas_hi < min_cas_hi) min_cas_hi = cas_hi;
        if (!we_n) begin
          logic [15:0] w;
          if (p_we) late_we++;
          w = peek({em_row, em_col});
          if (!cas_n[0]) w[7:0]  = dq_out[7:0];
          if (!cas_n[1]) w[15:8] = dq_out[15:8];
          mem[int'({em_row, em_col})] = w;
        end else if (oe_n || cas_n != 2'b00) bad_rd++;
      end
      if (cas_n != 2'b11) begin cas_low++; cas_hi = 0; end
      else begin
        if (cas_low != 0) begin
          if (cas_low != T_CAS) bad_width++;
          seen_pulse = 1'b1;
        end
        cas_low = 0;
        cas_hi++;
      end
      dq_in = (cas_n != 2'b11 && !oe_n) ? peek({em_row, em_col}) : 16'hxxxx;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end
  end

  task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1'b1, a, d, be);
    repeat (T_CAS + 3) @(negedge clk);
  endtask

  task automatic do_read(input logic [19:0] a, input logic [15:0] exp, input string req);
    int w = 0;
    issue(1'b0, a, 16'h0, 2'b11);
    while (!rsp_valid && w < 50) begin @(negedge clk); w++; end
    chk(rsp_valid && rsp_rdata === exp, req, rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid, "R5 single pulse", rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk(ras_n && cas_n == 2'b11 && we_n && oe_n, "R1 strobes idle", {ras_n, cas_n, we_n, oe_n}, 5'h1f);
    chk(!dq_oe && !rsp_valid && !ref_grant, "R1 outputs low", {dq_oe, rsp_valid, ref_grant}, 0);
  endtask

  task automatic t_mux();
    int a0 = act_cnt;
    do_write(20'h556AA, 16'h1234, 2'b11);
    chk(em_row == 10'h155 && em_col == 10'h2AA, "R2 row/col on pins", {em_row, em_col}, 20'h556AA);
    chk(peek(20'h556AA) == 16'h1234, "R2 stored at address", peek(20'h556AA), 16'h1234);
    chk(first_rcd == T_RCD + 1, "R7 ras-to-cas", first_rcd, T_RCD + 1);
    do_read(20'h556AA, 16'h1234, "R5 read data");
    chk(act_cnt == a0 + 1, "R6 one activation", act_cnt, a0 + 1);
  endtask

  task automatic t_page();
    int a0 = act_cnt;
    do_write(20'h55401, 16'hBEEF, 2'b11);
    do_read(20'h55401, 16'hBEEF, "R6 page read");
    do_read(20'h556AA, 16'h1234, "R6 page read 2");
    chk(act_cnt == a0, "R6 no new activation", act_cnt, a0);
    chk(!ras_n, "R6 row stays open", ras_n, 0);
  endtask

  task automatic t_bytes();
    do_write(20'h556AA, 16'hABCD, 2'b01);
    chk(peek(20'h556AA) == 16'h12CD, "R3 lower lane only", peek(20'h556AA), 16'h12CD);
    do_write(20'h556AA, 16'h5678, 2'b10);
    do_read(20'h556AA, 16'h56CD, "R3 upper lane only");
  endtask

  task automatic t_miss();
    int a0 = act_cnt;
    do_write(20'h0A00F, 16'hC0DE, 2'b11);
    chk(act_cnt == a0 + 1, "R7 new activation", act_cnt, a0 + 1);
    chk(bad_pre == 0, "R7 precharge time", bad_pre, 0);
    chk(first_rcd == T_RCD + 1, "R7 ras-to-cas after miss", first_rcd, T_RCD + 1);
    do_read(20'h556AA, 16'h56CD, "R7 old row data");
    do_read(20'h0A00F, 16'hC0DE, "R7 new row data");
  endtask

  task automatic t_limit();
    int a0;
    repeat (T_RAS_MAX + 10) @(negedge clk);
    chk(ras_n, "R8 idle row closed", ras_n, 1);
    a0 = act_cnt;
    for (int i = 0; i < 40; i++) do_read(20'h0A00F, 16'hC0DE, "R8 burst data");
    chk(act_cnt >= a0 + 3, "R8 row reopened", act_cnt, a0 + 3);
    chk(max_low <= T_RAS_MAX, "R8 max ras low", max_low, T_RAS_MAX);
  endtask

  task automatic t_refresh();
    int a0, w = 0;
    do_read(20'h556AA, 16'h56CD, "R9 open row");
    @(negedge clk);
    ref_req = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R9 ready low on request", req_ready, 0);
    while (!ref_grant && w < 20) begin @(negedge clk); w++; end
    chk(ref_grant && ras_n && cas_n == 2'b11, "R9 grant with row closed", {ref_grant, ras_n, cas_n}, 4'hf);
    ref_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(ref_grant && !req_ready && ras_n, "R9 grant held", {ref_grant, req_ready, ras_n}, 3'b101);
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
    chk(!ref_grant, "R9 grant released", ref_grant, 0);
    a0 = act_cnt;
    do_read(20'h556AA, 16'h56CD, "R9 read after refresh");
    chk(act_cnt == a0 + 1, "R9 reactivation", act_cnt, a0 + 1);
  endtask

  task automatic t_protocol();
    chk(bad_width == 0, "R10 cas width", bad_width, 0);
    chk(min_cas_hi >= 1, "R10 cas high gap", min_cas_hi, 1);
    chk(bad_cas == 0, "R10 cas under ras", bad_cas, 0);
    chk(late_we == 0, "R4 early write", late_we, 0);
    chk(bad_rd == 0, "R5 read strobes", bad_rd, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mux();
    t_page();
    t_bytes();
    t_miss();
    t_limit();
    t_refresh();
    t_protocol();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-all actual timeout expected completion");
      report();
    end
  end
endmodule